// File: doc/BRIEF.md
# Four-Channel DMA Channel Register File

This block holds the host-programmable state of a four-channel DMA controller and presents it to a separate transfer engine. A host reaches it through an 8-bit port interface: a 4-bit port number, write and read strobes, write data, and read data. Each channel owns a 16-bit base and current address, a 16-bit base and current count, an 8-bit page byte, a mode byte, a mask bit and a software request bit.

The 16-bit address and count values move over the 8-bit bus one byte at a time. A single byte-pointer flip-flop, shared by all channels, picks the low or the high byte. Software writes the clear port first, then issues exactly two accesses. Counts hold the transfer length minus one. The transfer engine pulses a per-channel step input once per transferred item. Each step moves the address and decrements the count. When the count passes zero, the channel either reloads from its base values or masks itself.

Top module: `dma_chan_regfile`

## Requirements
- R1: After reset every mask bit is 1, every request bit is 0, every terminal-count pulse is 0, every address, count, page and mode value is 0, and the byte pointer selects the low byte.
- R2: Ports 2n (address) and 2n+1 (count) of channel n carry one byte per access. A write or a read to any of these ports toggles the single shared byte pointer, so two consecutive accesses hit the low byte and then the high byte. Reads return that byte of the current value while io_rd is high.
- R3: A write to port 11 returns the byte pointer to the low byte, whatever the data.
- R4: Port 12+n writes channel n's page byte, which drives bits 23:16 of that channel's address output. Page accesses do not toggle the byte pointer. Stepping never changes the page, even when the 16-bit address wraps.
- R5: A byte written to a base address or base count sets the current copy to the whole new base value in the same cycle. Port reads and the engine outputs show the current copy.
- R6: Port 8 takes a channel in data bits 1:0. Bit 2 set masks that channel and bit 2 clear unmasks it. A read of port 8 returns the four mask bits in bits 3:0.
- R7: Port 9 uses the same format as port 8. Bit 2 set raises that channel's software request and bit 2 clear withdraws it.
- R8: A write to port 10 stores the whole byte as the mode of the channel named in bits 1:0, and leaves the other channels unchanged. The field layout is: type in bits 7:6 (00 demand, 01 single, 10 block, 11 cascade), decrement in bit 5, auto-initialise in bit 4, direction in bits 3:2 (00 verify, 01 write, 10 read), channel in bits 1:0.
- R9: A step pulse with a nonzero current count decrements the count by one. It also moves the current address by one: up when mode bit 5 is 0, down when it is 1.
- R10: A step pulse at current count 0 without auto-initialise has four effects. The count becomes all ones, the address moves as in R9, the mask bit sets (this overrides an unmask in the same cycle), and the channel's terminal-count output pulses high for one cycle after that clock edge.
- R11: A step pulse at current count 0 with auto-initialise has three effects. The current address and count reload from the base values, the terminal-count output pulses, and the mask bit is unchanged.
- R12: A host write to a channel's address or count port wins over a step pulse on that channel in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | Host port write strobe |
| io_rd | input | 1 | Host port read strobe |
| io_addr | input | 4 | Host port number |
| io_wdata | input | 8 | Host write data |
| io_rdata | output | 8 | Host read data, combinational while io_rd is high |
| ch_step | input | 4 | Per-channel transfer step pulse from the engine |
| ch_addr | output | 96 | Per-channel {page, current address}, 24 bits each |
| ch_count | output | 64 | Per-channel current count, 16 bits each |
| ch_mode | output | 32 | Per-channel mode byte |
| ch_mask | output | 4 | Per-channel mask bit |
| ch_req | output | 4 | Per-channel software request bit |
| ch_tc | output | 4 | Per-channel terminal-count pulse |

## Verification
Read data is combinational, so the bench samples it in the same cycle as the read strobe. The byte-pointer toggle, register writes, step effects and the terminal-count pulse all appear after the single clock edge that takes the strobe. Stimulus changes on the falling edge. Each task samples results on the next falling edge, after exactly one register stage. The terminal-count pulse is checked high in that cycle and low one cycle later.

// File: rtl/dma_rf_pkg.sv
package dma_rf_pkg;
    localparam int NCH     = 4;
    localparam int CH_W    = $clog2(NCH);
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int PAGE_W  = BYTE_W;
    localparam int IO_AW   = 4;
    localparam int EADDR_W = WORD_W + PAGE_W;

    localparam int PORT_MASK  = 2 * NCH;
    localparam int PORT_REQ   = 2 * NCH + 1;
    localparam int PORT_MODE  = 2 * NCH + 2;
    localparam int PORT_CLR   = 2 * NCH + 3;
    localparam int PORT_PAGE0 = 2 * NCH + 4;

    typedef enum logic [1:0] {
        XF_DEMAND  = 2'b00,
        XF_SINGLE  = 2'b01,
        XF_BLOCK   = 2'b10,
        XF_CASCADE = 2'b11
    } xfer_e;

    typedef enum logic [1:0] {
        DIR_VERIFY = 2'b00,
        DIR_WRITE  = 2'b01,
        DIR_READ   = 2'b10,
        DIR_RSVD   = 2'b11
    } dir_e;

    typedef struct packed {
        xfer_e             kind;
        logic              dec;
        logic              auto_init;
        dir_e              dir;
        logic [CH_W-1:0]   sel;
    } mode_t;
endpackage

// File: rtl/dma_rf_decode.sv
module dma_rf_decode
    import dma_rf_pkg::*;
(
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [CH_W:0]     cmd,
    output logic [NCH-1:0]    wr_addr,
    output logic [NCH-1:0]    wr_cnt,
    output logic [NCH-1:0]    wr_page,
    output logic [NCH-1:0]    wr_mode,
    output logic [NCH-1:0]    mask_set,
    output logic [NCH-1:0]    mask_clr,
    output logic [NCH-1:0]    req_set,
    output logic [NCH-1:0]    req_clr,
    output logic              ptr_clr,
    output logic              ptr_toggle
);
    logic mask_wr, req_wr, mode_wr;

    assign mask_wr    = io_wr && (io_addr == IO_AW'(PORT_MASK));
    assign req_wr     = io_wr && (io_addr == IO_AW'(PORT_REQ));
    assign mode_wr    = io_wr && (io_addr == IO_AW'(PORT_MODE));
    assign ptr_clr    = io_wr && (io_addr == IO_AW'(PORT_CLR));
    assign ptr_toggle = (io_wr || io_rd) && (io_addr < IO_AW'(2 * NCH));

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic hit;
        assign hit         = (cmd[CH_W-1:0] == CH_W'(g));
        assign wr_addr[g]  = io_wr && (io_addr == IO_AW'(2 * g));
        assign wr_cnt[g]   = io_wr && (io_addr == IO_AW'(2 * g + 1));
        assign wr_page[g]  = io_wr && (io_addr == IO_AW'(PORT_PAGE0 + g));
        assign wr_mode[g]  = mode_wr && hit;
        assign mask_set[g] = mask_wr && hit && cmd[CH_W];
        assign mask_clr[g] = mask_wr && hit && !cmd[CH_W];
        assign req_set[g]  = req_wr && hit && cmd[CH_W];
        assign req_clr[g]  = req_wr && hit && !cmd[CH_W];
    end
endmodule

// File: rtl/dma_rf_ptr.sv
module dma_rf_ptr (
    input  logic clk,
    input  logic rst_n,
    input  logic ptr_clr,
    input  logic ptr_toggle,
    output logic byte_hi
);
    logic hi_d, hi_q;

    always_comb begin
        hi_d = hi_q;
        if (ptr_clr) begin
            hi_d = 1'b0;
        end else if (ptr_toggle) begin
            hi_d = !hi_q;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= 1'b0;
        end else begin
            hi_q <= hi_d;
        end
    end

    assign byte_hi = hi_q;
endmodule

// File: rtl/dma_rf_chan.sv
module dma_rf_chan
    import dma_rf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               byte_hi,
    input  logic [BYTE_W-1:0]  wdata,
    input  logic               wr_addr,
    input  logic               wr_cnt,
    input  logic               wr_page,
    input  logic               wr_mode,
    input  logic               mask_set,
    input  logic               mask_clr,
    input  logic               req_set,
    input  logic               req_clr,
    input  logic               step,
    output logic [WORD_W-1:0]  cur_addr,
    output logic [WORD_W-1:0]  cur_cnt,
    output logic [PAGE_W-1:0]  page,
    output mode_t              mode,
    output logic               mask,
    output logic               req,
    output logic               tc
);
    typedef struct packed {
        logic [WORD_W-1:0] base_addr;
        logic [WORD_W-1:0] cur_addr;
        logic [WORD_W-1:0] base_cnt;
        logic [WORD_W-1:0] cur_cnt;
        logic [PAGE_W-1:0] page;
        mode_t             mode;
        logic              mask;
        logic              req;
        logic              tc;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic [WORD_W-1:0] addr_next;

    assign addr_next = st_q.mode.dec ? st_q.cur_addr - 1'b1 : st_q.cur_addr + 1'b1;

    always_comb begin
        st_d    = st_q;
        st_d.tc = 1'b0;

        // host mask and request ports
        if (mask_set) st_d.mask = 1'b1;
        if (mask_clr) st_d.mask = 1'b0;
        if (req_set)  st_d.req  = 1'b1;
        if (req_clr)  st_d.req  = 1'b0;
        if (wr_page)  st_d.page = wdata;
        if (wr_mode)  st_d.mode = mode_t'(wdata);

        // engine step; terminal count masking overrides a host unmask
        if (step) begin
            if (st_q.cur_cnt == '0) begin
                st_d.tc = 1'b1;
                if (st_q.mode.auto_init) begin
                    st_d.cur_addr = st_q.base_addr;
                    st_d.cur_cnt  = st_q.base_cnt;
                end else begin
                    st_d.cur_addr = addr_next;
                    st_d.cur_cnt  = '1;
                    st_d.mask     = 1'b1;
                end
            end else begin
                st_d.cur_addr = addr_next;
                st_d.cur_cnt  = st_q.cur_cnt - 1'b1;
            end
        end

        // host address/count writes win over the step
        if (wr_addr) begin
            if (byte_hi) st_d.base_addr[WORD_W-1:BYTE_W] = wdata;
            else         st_d.base_addr[BYTE_W-1:0]      = wdata;
            st_d.cur_addr = st_d.base_addr;
        end
        if (wr_cnt) begin
            if (byte_hi) st_d.base_cnt[WORD_W-1:BYTE_W] = wdata;
            else         st_d.base_cnt[BYTE_W-1:0]      = wdata;
            st_d.cur_cnt = st_d.base_cnt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.mask <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cur_addr = st_q.cur_addr;
    assign cur_cnt  = st_q.cur_cnt;
    assign page     = st_q.page;
    assign mode     = st_q.mode;
    assign mask     = st_q.mask;
    assign req      = st_q.req;
    assign tc       = st_q.tc;
endmodule

// File: rtl/dma_chan_regfile.sv
module dma_chan_regfile
    import dma_rf_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   io_wr,
    input  logic                   io_rd,
    input  logic [IO_AW-1:0]       io_addr,
    input  logic [BYTE_W-1:0]      io_wdata,
    output logic [BYTE_W-1:0]      io_rdata,
    input  logic [NCH-1:0]         ch_step,
    output logic [NCH*EADDR_W-1:0] ch_addr,
    output logic [NCH*WORD_W-1:0]  ch_count,
    output logic [NCH*BYTE_W-1:0]  ch_mode,
    output logic [NCH-1:0]         ch_mask,
    output logic [NCH-1:0]         ch_req,
    output logic [NCH-1:0]         ch_tc
);
    logic [NCH-1:0] wr_addr, wr_cnt, wr_page, wr_mode;
    logic [NCH-1:0] mask_set, mask_clr, req_set, req_clr;
    logic           ptr_clr, ptr_toggle, byte_hi;
    logic [WORD_W-1:0] cur_addr [NCH];
    logic [WORD_W-1:0] cur_cnt  [NCH];
    logic [PAGE_W-1:0] page     [NCH];
    mode_t             mode     [NCH];
    logic [NCH-1:0]    auto_vec;

    dma_rf_decode u_dec (
        .io_wr      (io_wr),
        .io_rd      (io_rd),
        .io_addr    (io_addr),
        .cmd        (io_wdata[CH_W:0]),
        .wr_addr    (wr_addr),
        .wr_cnt     (wr_cnt),
        .wr_page    (wr_page),
        .wr_mode    (wr_mode),
        .mask_set   (mask_set),
        .mask_clr   (mask_clr),
        .req_set    (req_set),
        .req_clr    (req_clr),
        .ptr_clr    (ptr_clr),
        .ptr_toggle (ptr_toggle)
    );

    dma_rf_ptr u_ptr (
        .clk        (clk),
        .rst_n      (rst_n),
        .ptr_clr    (ptr_clr),
        .ptr_toggle (ptr_toggle),
        .byte_hi    (byte_hi)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dma_rf_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .byte_hi  (byte_hi),
            .wdata    (io_wdata),
            .wr_addr  (wr_addr[g]),
            .wr_cnt   (wr_cnt[g]),
            .wr_page  (wr_page[g]),
            .wr_mode  (wr_mode[g]),
            .mask_set (mask_set[g]),
            .mask_clr (mask_clr[g]),
            .req_set  (req_set[g]),
            .req_clr  (req_clr[g]),
            .step     (ch_step[g]),
            .cur_addr (cur_addr[g]),
            .cur_cnt  (cur_cnt[g]),
            .page     (page[g]),
            .mode     (mode[g]),
            .mask     (ch_mask[g]),
            .req      (ch_req[g]),
            .tc       (ch_tc[g])
        );
        assign ch_addr[g*EADDR_W +: EADDR_W] = {page[g], cur_addr[g]};
        assign ch_count[g*WORD_W +: WORD_W]  = cur_cnt[g];
        assign ch_mode[g*BYTE_W +: BYTE_W]   = mode[g];
        assign auto_vec[g]                   = mode[g].auto_init;
    end

    always_comb begin
        io_rdata = '0;
        if (io_rd) begin
            for (int i = 0; i < NCH; i++) begin
                if (io_addr == IO_AW'(2 * i))
                    io_rdata = byte_hi ? cur_addr[i][WORD_W-1:BYTE_W] : cur_addr[i][BYTE_W-1:0];
                if (io_addr == IO_AW'(2 * i + 1))
                    io_rdata = byte_hi ? cur_cnt[i][WORD_W-1:BYTE_W] : cur_cnt[i][BYTE_W-1:0];
                if (io_addr == IO_AW'(PORT_PAGE0 + i))
                    io_rdata = page[i];
            end
            if (io_addr == IO_AW'(PORT_MASK))
                io_rdata = BYTE_W'(ch_mask);
        end
    end
endmodule

// File: rtl/dma_rf_checker.sv
module dma_rf_checker
    import dma_rf_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  io_wr,
    input logic [IO_AW-1:0]      io_addr,
    input logic [CH_W:0]         cmd,
    input logic [NCH-1:0]        ch_step,
    input logic [NCH-1:0]        ch_mask,
    input logic [NCH-1:0]        ch_tc,
    input logic [NCH*WORD_W-1:0] ch_count,
    input logic [NCH-1:0]        auto_vec,
    input logic                  byte_hi,
    input logic                  ptr_toggle
);
    // R2: each address/count access flips the shared pointer
    a_r2_ptr_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_toggle |=> (byte_hi != $past(byte_hi)));

    // R3: clear port returns pointer to low byte
    a_r3_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(PORT_CLR)) |=> !byte_hi);

    // R6: mask port with bit 2 set masks the named channel
    a_r6_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_addr == IO_AW'(PORT_MASK) && cmd[CH_W]) |=> ch_mask[$past(cmd[CH_W-1:0])]);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        // R9: plain step decrements the count
        a_r9_count_step: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_step[g] && !(io_wr && io_addr == IO_AW'(2 * g + 1)) && ch_count[g*WORD_W +: WORD_W] != '0)
            |=> (ch_count[g*WORD_W +: WORD_W] == $past(ch_count[g*WORD_W +: WORD_W]) - 1'b1));

        // R10: terminal count without auto-initialise leaves channel masked
        a_r10_tc_masks: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tc[g] && !$past(auto_vec[g])) |-> ch_mask[g]);

        // R11: terminal count with auto-initialise does not mask
        a_r11_tc_keeps_mask: assert property (@(posedge clk) disable iff (!rst_n)
            (ch_tc[g] && $past(auto_vec[g]) && !$past(ch_mask[g]) &&
             !$past(io_wr && io_addr == IO_AW'(PORT_MASK))) |-> !ch_mask[g]);
    end
endmodule

bind dma_chan_regfile dma_rf_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .io_wr      (io_wr),
    .io_addr    (io_addr),
    .cmd        (io_wdata[dma_rf_pkg::CH_W:0]),
    .ch_step    (ch_step),
    .ch_mask    (ch_mask),
    .ch_tc      (ch_tc),
    .ch_count   (ch_count),
    .auto_vec   (auto_vec),
    .byte_hi    (byte_hi),
    .ptr_toggle (ptr_toggle)
);

// File: tb/dma_chan_regfile_test.sv
module dma_chan_regfile_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_wr = 1'b0, io_rd = 1'b0;
    logic [3:0]  io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic [3:0]  ch_step = '0;
    logic [95:0] ch_addr;
    logic [63:0] ch_count;
    logic [31:0] ch_mode;
    logic [3:0]  ch_mask, ch_req, ch_tc;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    dma_chan_regfile uut (
        .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_rd(io_rd),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .ch_step(ch_step), .ch_addr(ch_addr), .ch_count(ch_count),
        .ch_mode(ch_mode), .ch_mask(ch_mask), .ch_req(ch_req), .ch_tc(ch_tc)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        io_rd = 1'b1; io_addr = a;
        #1 d = io_rdata;
        @(negedge clk);
        io_rd = 1'b0;
    endtask

    task automatic load16(input logic [3:0] a, input logic [15:0] v);
        wr(4'd11, 8'h00);
        wr(a, v[7:0]);
        wr(a, v[15:8]);
    endtask

    task automatic step(input int ch);
        @(negedge clk);
        ch_step[ch] = 1'b1;
        @(negedge clk);
        ch_step = '0;
    endtask

    function automatic logic [23:0] addr_of(input int ch);
        return ch_addr[24*ch +: 24];
    endfunction

    function automatic logic [15:0] cnt_of(input int ch);
        return ch_count[16*ch +: 16];
    endfunction

    task automatic t_reset;
        logic [7:0] d;
        check("R1 mask after reset", 32'(ch_mask), 32'hF);
        check("R1 req after reset", 32'(ch_req), 32'h0);
        check("R1 tc after reset", 32'(ch_tc), 32'h0);
        check("R1 count ch0 after reset", 32'(cnt_of(0)), 32'h0);
        check("R1 mode after reset", ch_mode, 32'h0);
        rd(4'd8, d);
        check("R1 mask port read after reset", 32'(d), 32'h0F);
    endtask

    task automatic t_bytes;
        logic [7:0] lo, hi;
        // pointer low out of reset: first write lands in the low byte
        wr(4'd2, 8'hEF);
        wr(4'd2, 8'hBE);
        check("R2 ch1 address assembled", 32'(addr_of(1)), 32'h00BEEF);
        rd(4'd2, lo);
        rd(4'd2, hi);
        check("R2 ch1 address low byte read", 32'(lo), 32'hEF);
        check("R2 ch1 address high byte read", 32'(hi), 32'hBE);
    endtask

    task automatic t_clear;
        wr(4'd0, 8'hAA);
        wr(4'd11, 8'h5C);
        wr(4'd0, 8'h11);
        wr(4'd0, 8'h22);
        check("R3 clear port restarts at low byte", 32'(addr_of(0)), 32'h002211);
    endtask

    task automatic t_page;
        wr(4'd11, 8'hFF);
        wr(4'd4, 8'h34);
        wr(4'd14, 8'h5A);
        wr(4'd4, 8'h12);
        check("R4 page bits and no pointer toggle", 32'(addr_of(2)), 32'h5A1234);
        check("R5 current follows base write", 32'(addr_of(2)), 32'h5A1234);
    endtask

    task automatic t_mask;
        logic [7:0] d;
        wr(4'd8, 8'h02);
        rd(4'd8, d);
        check("R6 unmask ch2", 32'(d), 32'h0B);
        wr(4'd8, 8'h06);
        check("R6 mask ch2 again", 32'(ch_mask), 32'hF);
    endtask

    task automatic t_req;
        wr(4'd9, 8'h06);
        check("R7 request ch2 raised", 32'(ch_req), 32'h4);
        wr(4'd9, 8'h02);
        check("R7 request ch2 withdrawn", 32'(ch_req), 32'h0);
    endtask

    task automatic t_mode;
        wr(4'd10, 8'hC7);
        check("R8 mode stored in ch3", 32'(ch_mode[31:24]), 32'hC7);
        check("R8 other channels untouched", 32'(ch_mode[23:0]), 32'h0);
    endtask

    task automatic t_tc;
        logic [7:0] lo, hi;
        wr(4'd10, 8'h48);             // single, increment, read, ch0
        load16(4'd0, 16'h0100);
        load16(4'd1, 16'h0002);
        wr(4'd8, 8'h00);              // unmask ch0
        step(0);
        check("R9 count after step", 32'(cnt_of(0)), 32'h0001);
        check("R9 address increment", 32'(addr_of(0)), 32'h000101);
        step(0);
        step(0);
        check("R10 tc pulse", 32'(ch_tc), 32'h1);
        check("R10 count all ones", 32'(cnt_of(0)), 32'hFFFF);
        check("R10 address stepped", 32'(addr_of(0)), 32'h000103);
        check("R10 mask set", 32'(ch_mask[0]), 32'h1);
        @(negedge clk);
        check("R10 tc one cycle only", 32'(ch_tc), 32'h0);
        wr(4'd11, 8'h00);
        rd(4'd1, lo);
        rd(4'd1, hi);
        check("R5 read returns current count", 32'({hi, lo}), 32'hFFFF);
    endtask

    task automatic t_dec;
        wr(4'd10, 8'h63);             // single, decrement, ch3
        wr(4'd15, 8'h7E);
        load16(4'd6, 16'h0001);
        load16(4'd7, 16'h0005);
        step(3);
        check("R9 address decrement", 32'(addr_of(3)), 32'h7E0000);
        step(3);
        check("R4 wrap keeps page", 32'(addr_of(3)), 32'h7EFFFF);
        check("R9 count after two steps", 32'(cnt_of(3)), 32'h0003);
    endtask

    task automatic t_auto;
        wr(4'd10, 8'h59);             // single, auto-init, read, ch1
        load16(4'd2, 16'h1000);
        load16(4'd3, 16'h0001);
        wr(4'd8, 8'h01);              // unmask ch1
        step(1);
        step(1);
        check("R11 tc pulse", 32'(ch_tc), 32'h2);
        check("R11 address reload", 32'(addr_of(1)), 32'h001000);
        check("R11 count reload", 32'(cnt_of(1)), 32'h0001);
        check("R11 mask unchanged", 32'(ch_mask[1]), 32'h0);
    endtask

    task automatic t_prio;
        load16(4'd5, 16'h0005);
        wr(4'd11, 8'h00);
        @(negedge clk);
        io_wr = 1'b1; io_addr = 4'd5; io_wdata = 8'h30; ch_step[2] = 1'b1;
        @(negedge clk);
        io_wr = 1'b0; ch_step = '0;
        check("R12 host count write wins over step", 32'(cnt_of(2)), 32'h0030);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_bytes();
        t_clear();
        t_page();
        t_mask();
        t_req();
        t_mode();
        t_tc();
        t_dec();
        t_auto();
        t_prio();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule